// File: doc/BRIEF.md
# Four-Phase Banked Vector Register File

This block holds the vector registers of one 64-lane SIMD unit. Each register is spread across four storage banks, and each bank keeps the 16 lanes of one lane group. Every bank has one port, which can either read or write in a given cycle. A single vector instruction is issued every four cycles. It has up to three source registers and one destination. The three operand fetches fall in the three cycles after acceptance, one source per cycle, and all four banks read in parallel. The fourth cycle belongs to execution. In that cycle no bank reads, so the banks write the result of the previous instruction then. The write of any result is therefore delayed by one issue slot.

Because writes are delayed, the register an instruction wants to read may not have reached the banks yet. A one-entry pending-write buffer keeps the most recent result and its destination index. Each operand fetch compares its source index against that buffer and takes the buffered value on a match. Back-to-back dependent instructions therefore run at full rate. The block needs no stalls, no scoreboard and no conflict check. The arithmetic is a small per-lane stub with four operations, and it exists only so that results can be observed.

Top module: `vrf_cadence_top`

## Requirements
- R1: `in_ready` is high in exactly one cycle of every four, including the first cycle after reset is released. A descriptor is taken only at the rising edge that ends an `in_ready` cycle. The `in_valid` input and the other descriptor inputs have no effect in any other cycle.
- R2: Lane `l` occupies bits `[l*DATA_W +: DATA_W]` of `opnd_data` and `res_data`, and it is stored in bank `l/16`. No bank reads and writes in the same cycle.
- R3: In the 1st, 2nd and 3rd cycle after acceptance, every bank reads source 0, source 1 and source 2 respectively, and `opnd_data` carries that operand. In an `in_ready` cycle no bank reads.
- R4: The opcode field `in_op` sets which sources are used: 0 = load-immediate uses none, 1 = move uses source 0, 2 = add uses sources 0 and 1, 3 = multiply-add uses all three. A read cycle whose source is unused has no read strobe, and the four-cycle rhythm stays the same.
- R5: `res_valid` is high in the `in_ready` cycle four cycles after an instruction is accepted, and `res_dst` then equals the accepted destination. An idle slot gives no result.
- R6: Results per lane, taken modulo 2^DATA_W: load-immediate gives `imm + l`, move gives `a`, add gives `a + b`, multiply-add gives `a*b + c`. Here a, b and c are sources 0, 1 and 2.
- R7: A result is written to all four banks in the `in_ready` cycle of the following slot, whether or not that slot holds an instruction. `bank_wr_en` is never high outside `in_ready` cycles.
- R8: An operand read returns the latest value written, in program order, to its register. This includes the result of the instruction just before, in any source position, and the case where an instruction's destination equals one of its sources. No stall cycle is ever added.
- R9: A register keeps the last value written to it until it is written again.
- R10: While reset is asserted, `in_ready` is high, and `res_valid`, `bank_rd_en` and `bank_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_ready | output | 1 | Issue slot open this cycle |
| in_valid | input | 1 | Descriptor present |
| in_op | input | 2 | Opcode (0 load-imm, 1 move, 2 add, 3 multiply-add) |
| in_src0 | input | $clog2(NREGS) | Source register 0 |
| in_src1 | input | $clog2(NREGS) | Source register 1 |
| in_src2 | input | $clog2(NREGS) | Source register 2 |
| in_dst | input | $clog2(NREGS) | Destination register |
| in_imm | input | DATA_W | Immediate for load-immediate |
| bank_rd_en | output | BANKS | Per-bank read strobe |
| bank_wr_en | output | BANKS | Per-bank write strobe |
| opnd_data | output | LANES*DATA_W | Operand being fetched, all lane slices |
| res_valid | output | 1 | Result present this cycle |
| res_dst | output | $clog2(NREGS) | Destination of the result |
| res_data | output | LANES*DATA_W | Result, all lane slices |

## Verification
The bench places a consumer behind a producer at distances of zero, one and two slots, with the dependency in each of the three source positions. A design that skipped the bypass would return stale bank data in the zero-distance case. A design that wrote one slot too late would fail the one-slot case. It also sends self-dependent instructions, busy bursts that reuse a four-register window, and descriptors presented outside the issue cycle. A register file that let the destination update before the sources were read, or that accepted descriptors outside the issue cycle, would produce wrong lanes or extra results. Lane-dependent immediates expose a wrong slice-to-bank mapping, and a final read-back of every register catches lost or misdirected writes.

// File: rtl/vrf_cad_pkg.sv
package vrf_cad_pkg;

   typedef enum logic [1:0] {
      OP_LDI = 2'd0,
      OP_MOV = 2'd1,
      OP_ADD = 2'd2,
      OP_MAD = 2'd3
   } vop_e;

   // which of the three operand fetch cycles carry a real read
   function automatic logic [2:0] src_mask(input vop_e op);
      logic [2:0] m;
      case (op)
         OP_LDI:  m = 3'b000;
         OP_MOV:  m = 3'b001;
         OP_ADD:  m = 3'b011;
         default: m = 3'b111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/vrf_phase_seq.sv
module vrf_phase_seq #(
   parameter int PHASES = 4,
   localparam int PH_W = $clog2(PHASES)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            slot_start
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (phase == PH_W'(PHASES - 1))
         phase <= '0;
      else
         phase <= phase + 1'b1;
   end

   assign slot_start = (phase == '0);

endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
   parameter int NREGS          = 16,
   parameter int SLICE_W        = 256,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW = $clog2(NREGS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [AW-1:0]      rd_addr,
   output logic [SLICE_W-1:0] rd_data,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic [SLICE_W-1:0] wr_data
);

   logic [SLICE_W-1:0] mem [NREGS];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREGS; i++) mem[i] <= '0;
            end else if (wr_en) begin
               mem[wr_addr] <= wr_data;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   endgenerate

   // read data is forced low when the port is not reading
   assign rd_data = rd_en ? mem[rd_addr] : '0;

   // the single port serves either a read or a write in any cycle (R2)
   p_single_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && wr_en));

endmodule

// File: rtl/vrf_slice_alu.sv
module vrf_slice_alu
   import vrf_cad_pkg::*;
#(
   parameter int LANES_PER = 16,
   parameter int DATA_W    = 16,
   parameter int BASE_LANE = 0,
   localparam int SW = LANES_PER * DATA_W
) (
   input  vop_e              op,
   input  logic [DATA_W-1:0] imm,
   input  logic [SW-1:0]     a,
   input  logic [SW-1:0]     b,
   input  logic [SW-1:0]     c,
   output logic [SW-1:0]     res
);

   generate
      for (genvar l = 0; l < LANES_PER; l++) begin : g_lane
         logic [DATA_W-1:0] la, lb, lc, lr;
         assign la = a[l*DATA_W +: DATA_W];
         assign lb = b[l*DATA_W +: DATA_W];
         assign lc = c[l*DATA_W +: DATA_W];
         always_comb begin
            case (op)
               OP_LDI:  lr = imm + DATA_W'(BASE_LANE + l);
               OP_MOV:  lr = la;
               OP_ADD:  lr = la + lb;
               default: lr = la * lb + lc;
            endcase
         end
         assign res[l*DATA_W +: DATA_W] = lr;
      end
   endgenerate

endmodule

// File: rtl/vrf_cadence_top.sv
module vrf_cadence_top
   import vrf_cad_pkg::*;
#(
   parameter int LANES          = 64,
   parameter int BANKS          = 4,
   parameter int DATA_W         = 16,
   parameter int NREGS          = 16,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int RIDX_W = $clog2(NREGS),
   localparam int VEC_W  = LANES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              in_ready,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [RIDX_W-1:0] in_src0,
   input  logic [RIDX_W-1:0] in_src1,
   input  logic [RIDX_W-1:0] in_src2,
   input  logic [RIDX_W-1:0] in_dst,
   input  logic [DATA_W-1:0] in_imm,
   output logic [BANKS-1:0]  bank_rd_en,
   output logic [BANKS-1:0]  bank_wr_en,
   output logic [VEC_W-1:0]  opnd_data,
   output logic              res_valid,
   output logic [RIDX_W-1:0] res_dst,
   output logic [VEC_W-1:0]  res_data
);

   localparam int N_SRC       = 3;
   localparam int PHASES      = N_SRC + 1;
   localparam int PH_W        = $clog2(PHASES);
   localparam int SLICE_LANES = LANES / BANKS;
   localparam int SLICE_W     = SLICE_LANES * DATA_W;

   generate
      if (LANES % BANKS != 0) begin : g_bad_split
         $error("LANES must divide evenly into BANKS");
      end
      if (NREGS < 2) begin : g_bad_regs
         $error("NREGS must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   // ---------------- issue rhythm ----------------
   logic [PH_W-1:0] phase;
   logic            slot;

   vrf_phase_seq #(.PHASES(PHASES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .phase      (phase),
      .slot_start (slot)
   );

   assign in_ready = slot;

   // ---------------- current descriptor ----------------
   logic              cur_v;
   vop_e              cur_op;
   logic [RIDX_W-1:0] cur_src [N_SRC];
   logic [RIDX_W-1:0] cur_dst;
   logic [DATA_W-1:0] cur_imm;
   logic [N_SRC-1:0]  cur_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_v   <= 1'b0;
         cur_op  <= OP_LDI;
         cur_dst <= '0;
         cur_imm <= '0;
         for (int k = 0; k < N_SRC; k++) cur_src[k] <= '0;
      end else if (slot) begin
         cur_v <= in_valid;
         if (in_valid) begin
            cur_op     <= vop_e'(in_op);
            cur_src[0] <= in_src0;
            cur_src[1] <= in_src1;
            cur_src[2] <= in_src2;
            cur_dst    <= in_dst;
            cur_imm    <= in_imm;
         end
      end
   end

   assign cur_mask = src_mask(cur_op);

   // ---------------- operand fetch ----------------
   logic [RIDX_W-1:0] raddr;
   logic              src_used;
   logic              rd_active;

   always_comb begin
      raddr    = '0;
      src_used = 1'b0;
      for (int k = 0; k < N_SRC; k++) begin
         if (phase == PH_W'(k + 1)) begin
            raddr    = cur_src[k];
            src_used = cur_mask[k];
         end
      end
   end

   assign rd_active  = cur_v && src_used;
   assign bank_rd_en = {BANKS{rd_active}};

   // ---------------- pending write slot ----------------
   logic              pend_v;
   logic [RIDX_W-1:0] pend_dst;
   logic [VEC_W-1:0]  pend_data;
   logic              wr_active;
   logic [VEC_W-1:0]  bank_rd_flat;
   logic [VEC_W-1:0]  exec_flat;
   logic              byp_hit;

   assign wr_active  = slot && pend_v;
   assign bank_wr_en = {BANKS{wr_active}};

   // ---------------- banks and lane-group ALUs ----------------
   logic [VEC_W-1:0] op_q [N_SRC];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         vrf_bank #(
            .NREGS          (NREGS),
            .SLICE_W        (SLICE_W),
            .CLEAR_ON_RESET (CLEAR_ON_RESET)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (rd_active),
            .rd_addr (raddr),
            .rd_data (bank_rd_flat[b*SLICE_W +: SLICE_W]),
            .wr_en   (wr_active),
            .wr_addr (pend_dst),
            .wr_data (pend_data[b*SLICE_W +: SLICE_W])
         );

         vrf_slice_alu #(
            .LANES_PER (SLICE_LANES),
            .DATA_W    (DATA_W),
            .BASE_LANE (b * SLICE_LANES)
         ) u_alu (
            .op  (cur_op),
            .imm (cur_imm),
            .a   (op_q[0][b*SLICE_W +: SLICE_W]),
            .b   (op_q[1][b*SLICE_W +: SLICE_W]),
            .c   (op_q[2][b*SLICE_W +: SLICE_W]),
            .res (exec_flat[b*SLICE_W +: SLICE_W])
         );
      end
   endgenerate

   // the result still waiting for its write slot overrides stale bank data
   assign byp_hit   = pend_v && (raddr == pend_dst);
   assign opnd_data = !rd_active ? '0 : (byp_hit ? pend_data : bank_rd_flat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N_SRC; k++) op_q[k] <= '0;
      end else begin
         for (int k = 0; k < N_SRC; k++)
            if (phase == PH_W'(k + 1)) op_q[k] <= opnd_data;
      end
   end

   // ---------------- execute and defer ----------------
   assign res_valid = slot && cur_v;
   assign res_dst   = cur_dst;
   assign res_data  = exec_flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_dst  <= '0;
         pend_data <= '0;
      end else if (slot) begin
         pend_v <= cur_v;
         if (cur_v) begin
            pend_dst  <= cur_dst;
            pend_data <= exec_flat;
         end
      end
   end

   // ---------------- assertions ----------------
   p_slot_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);

   p_slot_return_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> ##3 in_ready);

   p_all_banks_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_rd_en != '0) |-> (bank_rd_en == {BANKS{1'b1}}));

   p_no_read_in_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (bank_rd_en == '0));

   p_write_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_wr_en != '0) |-> in_ready);

   p_deferred_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> ##3 (bank_wr_en == {BANKS{1'b1}}));

   p_result_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && in_valid) |=> ##3 (res_valid && (res_dst == $past(in_dst, 4))));

endmodule

// File: tb/vrf_cadence_top_tb.sv
module vrf_cadence_top_tb;
   import vrf_cad_pkg::*;

   localparam int LANES = 64;
   localparam int BANKS = 4;
   localparam int W     = 16;
   localparam int NR    = 16;
   localparam int RW    = 4;
   localparam int VW    = LANES * W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_ready;
   logic          in_valid = 1'b0;
   logic [1:0]    in_op = 2'd0;
   logic [RW-1:0] in_src0 = '0, in_src1 = '0, in_src2 = '0, in_dst = '0;
   logic [W-1:0]  in_imm = '0;
   logic [BANKS-1:0] bank_rd_en, bank_wr_en;
   logic [VW-1:0] opnd_data, res_data;
   logic          res_valid;
   logic [RW-1:0] res_dst;

   always #4 clk = ~clk;   // 125 MHz

   vrf_cadence_top #(.LANES(LANES), .BANKS(BANKS), .DATA_W(W), .NREGS(NR)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_valid(in_valid),
      .in_op(in_op), .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2),
      .in_dst(in_dst), .in_imm(in_imm), .bank_rd_en(bank_rd_en),
      .bank_wr_en(bank_wr_en), .opnd_data(opnd_data), .res_valid(res_valid),
      .res_dst(res_dst), .res_data(res_data)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // flat reference register file, updated in program order
   logic [W-1:0]  rf [NR][LANES];
   logic [VW-1:0] exp_res = '0;
   logic          exp_res_v = 1'b0;
   logic [RW-1:0] exp_dst = '0;
   logic          exp_wr = 1'b0;
   logic [VW-1:0] exp_src [3];
   logic [2:0]    exp_mask = 3'b000;
   string         res_tag = "R6";

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_vec(input string req, input string what,
                          input logic [VW-1:0] act, input logic [VW-1:0] exp);
      int bad_l = -1;
      for (int l = LANES - 1; l >= 0; l--)
         if (act[l*W +: W] !== exp[l*W +: W]) bad_l = l;
      if (bad_l < 0)
         chk(1'b1, req, what, 64'd0, 64'd0);
      else
         chk(1'b0, req, $sformatf("%s lane %0d", what, bad_l),
             64'(act[bad_l*W +: W]), 64'(exp[bad_l*W +: W]));
   endtask

   // R4 encoding: 0 none, 1 src0, 2 src0+src1, 3 all three
   function automatic logic [2:0] used_of(input logic [1:0] op);
      case (op)
         2'd0:    return 3'b000;
         2'd1:    return 3'b001;
         2'd2:    return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

   // called at the falling edge inside an in_ready cycle; returns at the next one
   task automatic slot(input bit v, input logic [1:0] op, input int s0, input int s1,
                       input int s2, input int d, input int imm);
      logic [VW-1:0] nv;
      logic [W-1:0]  a, b, c;
      logic [2:0]    m;
      chk(in_ready === 1'b1, "R1", "in_ready at slot", 64'(in_ready), 64'd1);
      chk(res_valid === exp_res_v, "R5", "res_valid", 64'(res_valid), 64'(exp_res_v));
      if (exp_res_v) begin
         chk(res_dst === exp_dst, "R5", "res_dst", 64'(res_dst), 64'(exp_dst));
         // lane l at bits l*W checks the bank mapping of R2 as well
         chk_vec(res_tag, "result", res_data, exp_res);
      end
      chk(bank_wr_en === (exp_wr ? 4'hF : 4'h0), "R7", "write strobes in slot",
          64'(bank_wr_en), exp_wr ? 64'hF : 64'h0);
      chk(bank_rd_en === 4'h0, "R3", "no read in exec cycle", 64'(bank_rd_en), 64'd0);
      m  = v ? used_of(op) : 3'b000;
      nv = '0;
      if (v) begin
         for (int l = 0; l < LANES; l++) begin
            a = rf[s0][l]; b = rf[s1][l]; c = rf[s2][l];
            exp_src[0][l*W +: W] = a;
            exp_src[1][l*W +: W] = b;
            exp_src[2][l*W +: W] = c;
            case (op)
               2'd0:    nv[l*W +: W] = W'(imm + l);
               2'd1:    nv[l*W +: W] = a;
               2'd2:    nv[l*W +: W] = a + b;
               default: nv[l*W +: W] = a * b + c;
            endcase
         end
         for (int l = 0; l < LANES; l++) rf[d][l] = nv[l*W +: W];
      end
      in_valid = v; in_op = op; in_src0 = RW'(s0); in_src1 = RW'(s1);
      in_src2 = RW'(s2); in_dst = RW'(d); in_imm = W'(imm);
      exp_wr    = exp_res_v;
      exp_res_v = v;
      exp_res   = nv;
      exp_dst   = RW'(d);
      exp_mask  = m;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (k == 0) begin
            // junk outside the issue cycle must be ignored (R1)
            in_valid = 1'b1; in_op = 2'($urandom); in_src0 = RW'($urandom);
            in_src1 = RW'($urandom); in_src2 = RW'($urandom);
            in_dst = RW'($urandom); in_imm = W'($urandom);
         end
         chk(in_ready === 1'b0, "R1", "in_ready between slots", 64'(in_ready), 64'd0);
         chk(bank_wr_en === 4'h0, "R7", "write outside slot", 64'(bank_wr_en), 64'd0);
         chk((bank_rd_en & bank_wr_en) === 4'h0, "R2", "single port use",
             64'(bank_rd_en & bank_wr_en), 64'd0);
         if (exp_mask[k]) begin
            chk(bank_rd_en === 4'hF, "R3", $sformatf("read strobes src%0d", k),
                64'(bank_rd_en), 64'hF);
            chk_vec("R8", $sformatf("operand src%0d", k), opnd_data, exp_src[k]);
         end else begin
            chk(bank_rd_en === 4'h0, "R4", $sformatf("idle read src%0d", k),
                64'(bank_rd_en), 64'd0);
         end
      end
      @(negedge clk);
   endtask

   task automatic idle();
      slot(1'b0, 2'd0, 0, 0, 0, 0, 0);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog expired: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      for (int r = 0; r < NR; r++)
         for (int l = 0; l < LANES; l++) rf[r][l] = '0;
      for (int k = 0; k < 3; k++) exp_src[k] = '0;
      repeat (3) @(negedge clk);
      // R10: state held during reset
      chk(in_ready === 1'b1, "R10", "in_ready in reset", 64'(in_ready), 64'd1);
      chk(res_valid === 1'b0, "R10", "res_valid in reset", 64'(res_valid), 64'd0);
      chk(bank_rd_en === 4'h0, "R10", "rd strobes in reset", 64'(bank_rd_en), 64'd0);
      chk(bank_wr_en === 4'h0, "R10", "wr strobes in reset", 64'(bank_wr_en), 64'd0);
      rst_n = 1'b1;

      // R6: load-immediate every register with lane-dependent values
      for (int r = 0; r < NR; r++) slot(1'b1, 2'd0, 0, 0, 0, r, r * 1237 + 11);

      // R8: dependency in each source position at distance 0, 1 and 2 slots
      for (int p = 0; p < 3; p++)
         for (int gap = 0; gap < 3; gap++)
            for (int fill = 0; fill < 2; fill++) begin
               slot(1'b1, 2'd3, 2, 3, 4, 1, 0);
               for (int g = 0; g < gap; g++) begin
                  if (fill == 1) slot(1'b1, 2'd0, 0, 0, 0, 9, p * 100 + g);
                  else idle();
               end
               slot(1'b1, 2'd3, p == 0 ? 1 : 5, p == 1 ? 1 : 5, p == 2 ? 1 : 5, 6, 0);
            end

      // R8: destination equal to its own sources, back to back
      for (int i = 0; i < 4; i++) slot(1'b1, 2'd3, 7, 7, 7, 7, 0);
      slot(1'b1, 2'd2, 7, 7, 0, 8, 0);
      slot(1'b1, 2'd2, 8, 8, 0, 8, 0);

      // R4/R6: mixed busy stream in a narrow register window
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 8 == 0) idle();
         else begin
            int w = (i % 5 == 0) ? NR : 4;
            slot(1'b1, 2'($urandom), int'($urandom % w), int'($urandom % w),
                 int'($urandom % w), int'($urandom % w), int'($urandom % 65536));
         end
      end

      // R9: read back every register through a move onto itself
      idle();
      for (int r = 0; r < NR; r++) begin
         slot(1'b1, 2'd1, r, 0, 0, r, 0);
         res_tag = "R9";
      end
      idle();
      idle();
      summary();
      $finish;
   end

endmodule